// File: doc/BRIEF.md
# Flash Command Unlock Sequence Decoder

This block sits behind the asynchronous write port of a NOR-style flash device and recognises the multi-write command sequences that change how the device answers reads. The write enable is active low. A write takes effect when the strobe returns high. The block samples the strobe with the system clock, so a write is acted on at the first clock edge that sees the strobe high after it was low.

A command starts with two unlock writes and ends with a command write. The first unlock write carries AAh at 555h. The second carries 55h at 2AAh. The command write goes to 555h. Only address bits A11..A0 and data bits D7..D0 are compared. Three command bytes are recognised:
- 88h enters secure-sector mode.
- 90h opens a protection-status read.
- 58h opens a lock-status read.

While the 90h status read is open, a write of 00h leaves secure-sector mode. A write of F0h at any point cancels whatever is pending. Any write that breaks the pattern quietly sends the decoder back to idle.

Reads are combinational from the address. In a status mode, the data bus carries one status bit for the sector that A(max)..A(SECT_LSB) selects. In every other case it carries the array data, which arrives here on a pass-through input.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is acted on only at the first clock edge that sees we_n high after a clock edge saw it low. While we_n stays low, secure_o and rd_mode_o hold their values.
- R2: A command is accepted only after AAh at address 555h, then 55h at address 2AAh, then the command byte at address 555h. Only addr[11:0] and wdata[7:0] are compared; higher bits may hold any value.
- R3: A write whose address or data does not fit the expected step returns the decoder to idle. No error is raised. A later command byte has no effect unless a full unlock comes first.
- R4: A write with wdata[7:0]=F0h, at any address and in any state, sets rd_mode_o to 2'b00 (array) and drops any partial sequence. It leaves secure_o unchanged.
- R5: Command byte 88h sets secure_o to 1 and leaves rd_mode_o at 2'b00.
- R6: While rd_mode_o is 2'b01, a write of 00h at any address clears secure_o and sets rd_mode_o to 2'b00. Any other write that is not F0h sets rd_mode_o to 2'b00 and leaves secure_o unchanged.
- R7: Command byte 90h sets rd_mode_o to 2'b01. A read then returns sect_prot[addr[ADDR_W-1:SECT_LSB]] on bit 0, with all other bits 0.
- R8: Command byte 58h sets rd_mode_o to 2'b10. A read then returns lock_i on bit 1, with all other bits 0.
- R9: When rd_mode_o is 2'b00, rdata equals array_data.
- R10: A status mode persists across any number of reads at any addresses until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the write strobe |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_n | input | 1 | Active-low write strobe; a write completes when it rises |
| addr | input | ADDR_W | Bus address, used for both writes and reads |
| wdata | input | DATA_W | Write data |
| array_data | input | DATA_W | Array read data passed through in array mode |
| sect_prot | input | 2**(ADDR_W-SECT_LSB) | Protection indicator, one bit per sector |
| lock_i | input | 1 | Protection lock status |
| rdata | output | DATA_W | Read data |
| secure_o | output | 1 | 1 while secure-sector mode is active |
| rd_mode_o | output | 2 | 00 array, 01 protection status, 10 lock status |

## Verification
The bench builds the decoder with ADDR_W=16, DATA_W=16 and SECT_LSB=12. This gives sixteen sectors, so sector selection through A15..A12 can be checked against a known protection pattern. The 16-bit data and address widths let the unlock writes carry nonzero bits above D7 and A11, which shows that those bits are ignored. They also let a mismatched address such as 556h be told apart from 555h.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12,
  localparam int SW      = ADDR_W - SECT_LSB,
  localparam int NSECT   = 1 << SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] array_data,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic              lock_i,
  output logic [DATA_W-1:0] rdata,
  output logic              secure_o,
  output logic [1:0]        rd_mode_o
);
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PST, S_LST} st_t;

  st_t  st, nxt;
  logic we_q, sec_n, wr_ev;
  logic [11:0] a_lo;
  logic [7:0]  d_lo;
  logic start;

  assign wr_ev = !we_q && we_n;
  assign a_lo  = addr[11:0];
  assign d_lo  = wdata[7:0];
  assign start = (a_lo == 12'h555) && (d_lo == 8'hAA);

  always_comb begin
    nxt   = st;
    sec_n = secure_o;
    if (wr_ev) begin
      nxt = S_IDLE;
      if (d_lo != 8'hF0) begin
        case (st)
          S_U1: if (a_lo == 12'h2AA && d_lo == 8'h55) nxt = S_U2;
          S_U2: if (a_lo == 12'h555) begin
            case (d_lo)
              8'h88:   sec_n = 1'b1;
              8'h90:   nxt = S_PST;
              8'h58:   nxt = S_LST;
              default: nxt = S_IDLE;
            endcase
          end
          S_PST: begin
            if (d_lo == 8'h00) sec_n = 1'b0;
            else if (start)    nxt = S_U1;
          end
          default: if (start) nxt = S_U1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      we_q     <= 1'b1;
      secure_o <= 1'b0;
    end else begin
      st       <= nxt;
      we_q     <= we_n;
      secure_o <= sec_n;
    end
  end

  assign rd_mode_o = (st == S_PST) ? 2'b01 : (st == S_LST) ? 2'b10 : 2'b00;

  logic [SW-1:0] sect;
  assign sect = addr[ADDR_W-1:SECT_LSB];

  always_comb begin
    rdata = '0;
    case (rd_mode_o)
      2'b01:   rdata[0] = sect_prot[sect];
      2'b10:   rdata[1] = lock_i;
      default: rdata = array_data;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ev,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rdata,
  input logic              secure_o,
  input logic [1:0]        rd_mode_o
);
  assert_hold_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> ($stable(secure_o) && $stable(rd_mode_o)));

  assert_f0_to_array_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && wdata[7:0] == 8'hF0) |=> (rd_mode_o == 2'b00 && $stable(secure_o)));

  assert_secure_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secure_o) |-> $past(wr_ev && wdata[7:0] == 8'h88 && addr[11:0] == 12'h555));

  assert_secure_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secure_o) |-> $past(wr_ev && wdata[7:0] == 8'h00 && rd_mode_o == 2'b01));

  assert_prot_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode_o == 2'b01) |-> (rdata[DATA_W-1:1] == '0));

  assert_lock_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode_o == 2'b10) |-> (rdata[0] == 1'b0 && rdata[DATA_W-1:2] == '0));

  assert_array_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode_o == 2'b00) |-> (rdata == array_data));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .addr(addr), .wdata(wdata),
  .array_data(array_data), .rdata(rdata), .secure_o(secure_o), .rd_mode_o(rd_mode_o)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 16, SL = 12;
  localparam int NS = 1 << (AW - SL);

  logic clk = 0, rst_n = 0, we_n = 1, lock_i = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, array_data = 16'h1234, rdata;
  logic [NS-1:0] sect_prot = 16'h0008;
  logic secure_o;
  logic [1:0] rd_mode_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .SECT_LSB(SL)) u_dut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .array_data(array_data), .sect_prot(sect_prot), .lock_i(lock_i),
    .rdata(rdata), .secure_o(secure_o), .rd_mode_o(rd_mode_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk);
  endtask

  task automatic unlock(logic [DW-1:0] cmd);
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
    wr(16'h0555, cmd);
  endtask

  task automatic rd(logic [AW-1:0] a);
    addr = a; #1;
  endtask

  task automatic t_reset;
    chk("R9 reset mode", rd_mode_o, 2'b00);
    chk("R5 reset secure", secure_o, 0);
    rd(16'h0100); chk("R9 pass", rdata, 16'h1234);
    array_data = 16'hBEEF; #1; chk("R9 pass2", rdata, 16'hBEEF);
  endtask

  task automatic t_entry_upper_bits;
    wr(16'hF555, 16'h3CAA);
    wr(16'hA2AA, 16'hFF55);
    @(negedge clk); addr = 16'h7555; wdata = 16'h1288; we_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 held low", secure_o, 0);
    we_n = 1; @(negedge clk);
    chk("R2 R5 secure entered", secure_o, 1);
    chk("R5 mode", rd_mode_o, 2'b00);
  endtask

  task automatic t_prot_status;
    unlock(16'h0090);
    chk("R7 mode", rd_mode_o, 2'b01);
    rd(16'h3000); chk("R7 sector3", rdata, 16'h0001);
    rd(16'hA000); chk("R7 sector10", rdata, 16'h0000);
    rd(16'h3FFF); chk("R10 persists", rdata, 16'h0001);
    chk("R10 mode", rd_mode_o, 2'b01);
    wr(16'h4321, 16'h0000);
    chk("R6 exit secure", secure_o, 0);
    chk("R6 mode", rd_mode_o, 2'b00);
  endtask

  task automatic t_lock_status;
    lock_i = 1;
    unlock(16'h0058);
    rd(16'h5000); chk("R8 lock1", rdata, 16'h0002);
    lock_i = 0; #1; chk("R8 lock0", rdata, 16'h0000);
    wr(16'h0123, 16'h00F0);
    chk("R4 F0 to array", rd_mode_o, 2'b00);
    #1; chk("R9 after F0", rdata, 16'hBEEF);
  endtask

  task automatic t_mismatch;
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0054); wr(16'h0555, 16'h0088);
    chk("R3 bad data", secure_o, 0);
    wr(16'h0556, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0090);
    chk("R3 bad addr", rd_mode_o, 2'b00);
    wr(16'h0555, 16'h00AA); wr(16'h0000, 16'h00F0); wr(16'h0555, 16'h0088);
    chk("R4 F0 drops partial", secure_o, 0);
  endtask

  task automatic t_secure_keep;
    unlock(16'h0088);
    wr(16'h0000, 16'h00F0);
    chk("R4 F0 keeps secure", secure_o, 1);
    unlock(16'h0090);
    wr(16'h0000, 16'h0012);
    chk("R6 other write keeps secure", secure_o, 1);
    chk("R6 other write mode", rd_mode_o, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_entry_upper_bits();
    t_prot_status();
    t_lock_status();
    t_mismatch();
    t_secure_keep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule